// File: doc/BRIEF.md
# Synthesizer Power-Down Sequencer

This block decides when the core of a frequency synthesizer is switched off. Software loads two mode bits and commits them with a latch-enable strobe. A rising edge of that strobe either starts a power-down, ends one, or arms a deferred power-down. A deferred power-down waits for the reference divider's output pulse, so that the loop is not disturbed while the charge pump is mid-correction. A hardware chip-enable pin takes priority over all software settings.

The block produces one power-down state and a set of side-effect controls derived from it. These controls hold the dividers and the timeout counter at their load value, float the charge pump, clear lock detection, and remove the output and reference-buffer enables. A status flag shows when a deferred power-down has been armed and is still waiting for its reference edges. All inputs are sampled on the system clock. Edges of the strobe and of the reference pulse are found by comparing each input with its value on the previous clock.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset with the chip enable high, the power-down output is 0, the pending flag is 0 and both enables are 1.
- R2: A strobe rising edge with request bit = 1 and mode bit = 0 (immediate mode) sets power-down on the clock edge that samples the strobe high. The output is therefore visible one clock after the strobe is driven high.
- R3: A strobe rising edge with request bit = 1 and mode bit = 1 (deferred mode) arms a pending power-down. Power-down is set on the clock edge that samples the second reference rising edge seen after that strobe edge. A reference edge sampled on the same clock as the strobe edge is not counted.
- R4: While the chip enable is 0, the power-down output is 1 in the same cycle, whatever the mode bits hold. When the chip enable returns to 1, the software state decides the output again.
- R5: The divider hold, charge-pump float and lock-detect reset outputs are each equal to the power-down output. The output enable and the reference-buffer enable are each its inverse.
- R6: A strobe rising edge with request bit = 0 clears power-down on the next clock. It also cancels any pending deferred power-down.
- R7: A new deferred-mode strobe edge while a request is pending restarts the reference-edge count from zero.
- R8: The pending flag is 1 exactly from the clock that arms a deferred request until the clock that completes or cancels it.
- R9: A deferred-mode strobe edge that arrives while power-down is already set keeps the block powered down and does not arm the pending flag.
- R10: The request and mode bits have no effect unless the strobe rises, and reference edges have no effect unless a request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en_i | input | 1 | Hardware enable; 0 forces power-down |
| pd_req_i | input | 1 | Power-down request bit from the control register |
| pd_mode_i | input | 1 | 0 = immediate, 1 = deferred to reference edges |
| latch_i | input | 1 | Register latch strobe; its rising edge commits the bits |
| ref_pulse_i | input | 1 | Reference divider output pulse |
| pwr_down_o | output | 1 | Power-down state |
| sync_pending_o | output | 1 | Deferred power-down armed and waiting |
| div_hold_o | output | 1 | Hold dividers and timeout counter at load value |
| cp_float_o | output | 1 | Force the charge pump to three-state |
| lock_clr_o | output | 1 | Reset the digital lock detector |
| out_en_o | output | 1 | RF output enable |
| refbuf_en_o | output | 1 | Reference input buffer enable |

## Verification
The assertions assume that the strobe and the reference pulse are synchronous, clean levels held for at least one clock. They also assume that the request and mode bits are stable on the clock where the strobe rises, so that edge detection by comparing with the previous sample is exact. The stimulus drives every input on the falling clock edge. It holds each strobe and reference pulse high for one full cycle and low for at least one cycle before the next pulse. It sets the mode bits a cycle before raising the strobe. Reference pulses that coincide with a strobe edge are produced on purpose, and they stay within these rules because both are clean one-cycle levels.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  // Side-effect controls applied while the core is powered down.
  typedef struct packed {
    logic div_hold;
    logic cp_float;
    logic lock_clr;
    logic out_en;
    logic refbuf_en;
  } pd_fx_t;

  localparam int unsigned DEFAULT_SYNC_EDGES = 2;

endpackage

// File: rtl/pdc_edge_det.sv
module pdc_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/pdc_seq.sv
module pdc_seq #(
  parameter int unsigned SYNC_EDGES = pdc_pkg::DEFAULT_SYNC_EDGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic latch_rise_i,
  input  logic ref_rise_i,
  input  logic pd_req_i,
  input  logic pd_mode_i,
  output logic sw_pd_o,
  output logic pending_o
);

  localparam int unsigned CNT_W = (SYNC_EDGES > 1) ? $clog2(SYNC_EDGES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_EDGES - 1);

  logic             sw_q, sw_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  // The registers change only on a strobe edge or on a counted reference edge.
  assign upd_en = latch_rise_i | (pend_q & ref_rise_i);

  always_comb begin
    sw_d   = sw_q;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    if (latch_rise_i) begin
      if (!pd_req_i) begin
        sw_d   = 1'b0;
        pend_d = 1'b0;
      end else if (!pd_mode_i || sw_q) begin
        sw_d   = 1'b1;
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (pend_q && ref_rise_i) begin
      if (cnt_q == LAST) begin
        sw_d   = 1'b1;
        pend_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (upd_en) begin
      sw_q   <= sw_d;
      pend_q <= pend_d;
      cnt_q  <= cnt_d;
    end
  end

  assign sw_pd_o   = sw_q;
  assign pending_o = pend_q;

  a_r2_immediate_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise_i && pd_req_i && !pd_mode_i) |=> sw_pd_o);

  a_r3_deferred_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ref_rise_i && !latch_rise_i && cnt_q == LAST) |=> (sw_pd_o && !pending_o));

  a_r3_no_early_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && ref_rise_i && !latch_rise_i && cnt_q != LAST) |=> (!sw_pd_o && pending_o));

  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise_i && !pd_req_i) |=> (!sw_pd_o && !pending_o));

  a_r8_pending_excl: assert property (@(posedge clk) disable iff (!rst_n)
    pending_o |-> !sw_pd_o);

  a_r9_stay_down: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_rise_i && pd_req_i && sw_pd_o) |=> (sw_pd_o && !pending_o));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_rise_i && !(pend_q && ref_rise_i)) |=> ($stable(sw_pd_o) && $stable(pending_o)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/pdc_fx_out.sv
module pdc_fx_out
  import pdc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pwr_down_i,
  output pd_fx_t fx_o
);

  always_comb begin
    fx_o.div_hold  = pwr_down_i;
    fx_o.cp_float  = pwr_down_i;
    fx_o.lock_clr  = pwr_down_i;
    fx_o.out_en    = ~pwr_down_i;
    fx_o.refbuf_en = ~pwr_down_i;
  end

  a_r5_side_effects: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_i |-> (fx_o.div_hold && fx_o.cp_float && fx_o.lock_clr
                    && !fx_o.out_en && !fx_o.refbuf_en));

  a_r5_running: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_down_i |-> (!fx_o.div_hold && !fx_o.cp_float && !fx_o.lock_clr
                     && fx_o.out_en && fx_o.refbuf_en));

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
  import pdc_pkg::*;
#(
  parameter int unsigned SYNC_EDGES = DEFAULT_SYNC_EDGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chip_en_i,
  input  logic pd_req_i,
  input  logic pd_mode_i,
  input  logic latch_i,
  input  logic ref_pulse_i,
  output logic pwr_down_o,
  output logic sync_pending_o,
  output logic div_hold_o,
  output logic cp_float_o,
  output logic lock_clr_o,
  output logic out_en_o,
  output logic refbuf_en_o
);

  logic   latch_rise, ref_rise;
  logic   sw_pd;
  pd_fx_t fx;

  pdc_edge_det u_latch_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(latch_i), .rise_o(latch_rise)
  );

  pdc_edge_det u_ref_edge (
    .clk(clk), .rst_n(rst_n), .sig_i(ref_pulse_i), .rise_o(ref_rise)
  );

  pdc_seq #(.SYNC_EDGES(SYNC_EDGES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .latch_rise_i(latch_rise), .ref_rise_i(ref_rise),
    .pd_req_i(pd_req_i), .pd_mode_i(pd_mode_i),
    .sw_pd_o(sw_pd), .pending_o(sync_pending_o)
  );

  // Hardware enable overrides software state without waiting for a clock.
  assign pwr_down_o = ~chip_en_i | sw_pd;

  pdc_fx_out u_fx (
    .clk(clk), .rst_n(rst_n), .pwr_down_i(pwr_down_o), .fx_o(fx)
  );

  assign div_hold_o  = fx.div_hold;
  assign cp_float_o  = fx.cp_float;
  assign lock_clr_o  = fx.lock_clr;
  assign out_en_o    = fx.out_en;
  assign refbuf_en_o = fx.refbuf_en;

  a_r4_chip_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en_i |-> pwr_down_o);

endmodule

// File: tb/pwrdn_ctrl_tb_top.sv
module pwrdn_ctrl_tb_top;

  logic clk = 1'b0;
  logic rst_n, chip_en, pd_req, pd_mode, latch, refp;
  logic pwr_down, pending, div_hold, cp_float, lock_clr, out_en, refbuf_en;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string phase = "R1";

  // behavioural reference state
  int m_down = 0, m_pend = 0, m_edges = 0;
  int m_prev_latch = 0, m_prev_ref = 0;

  always #4 clk = ~clk;

  pwrdn_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .chip_en_i(chip_en), .pd_req_i(pd_req),
    .pd_mode_i(pd_mode), .latch_i(latch), .ref_pulse_i(refp),
    .pwr_down_o(pwr_down), .sync_pending_o(pending), .div_hold_o(div_hold),
    .cp_float_o(cp_float), .lock_clr_o(lock_clr), .out_en_o(out_en),
    .refbuf_en_o(refbuf_en)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Model update on each clock edge from pre-edge input values.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_down = 0; m_pend = 0; m_edges = 0; m_prev_latch = 0; m_prev_ref = 0;
    end else begin
      if (latch && !m_prev_latch) begin
        if (!pd_req) begin
          m_down = 0; m_pend = 0;
        end else if (!pd_mode || m_down) begin
          m_down = 1; m_pend = 0;
        end else begin
          m_pend = 1; m_edges = 0;
        end
      end else if (m_pend && refp && !m_prev_ref) begin
        m_edges = m_edges + 1;
        if (m_edges == 2) begin
          m_down = 1; m_pend = 0; m_edges = 0;
        end
      end
      m_prev_latch = int'(latch);
      m_prev_ref = int'(refp);
    end
  end

  // Compare 2 ns after every rising edge.
  always @(posedge clk) begin
    #2;
    cycles++;
    if (rst_n) begin
      automatic int exp_pd = (!chip_en || m_down) ? 1 : 0;
      check(phase, int'(pwr_down), exp_pd);
      check("R8", int'(pending), m_pend);
      check("R5", int'(div_hold), exp_pd);
      check("R5", int'(cp_float), exp_pd);
      check("R5", int'(lock_clr), exp_pd);
      check("R5", int'(out_en), 1 - exp_pd);
      check("R5", int'(refbuf_en), 1 - exp_pd);
    end
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe(input logic req, input logic mode);
    pd_req = req; pd_mode = mode; step(1);
    latch = 1'b1; step(1);
    latch = 1'b0; step(1);
  endtask

  task automatic ref_tick();
    refp = 1'b1; step(1);
    refp = 1'b0; step(1);
  endtask

  initial begin
    rst_n = 1'b0; chip_en = 1'b1; pd_req = 1'b0; pd_mode = 1'b0;
    latch = 1'b0; refp = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(2);
    // R1 reset state
    check("R1", int'(pwr_down), 0);
    check("R1", int'(pending), 0);
    check("R1", int'(out_en), 1);

    // R2 immediate entry: visible one clock after strobe high
    phase = "R2";
    pd_req = 1'b1; pd_mode = 1'b0; step(1);
    latch = 1'b1; step(1);
    check("R2", int'(pwr_down), 1);
    latch = 1'b0; step(2);

    // R6 clear by writing request = 0
    phase = "R6";
    strobe(1'b0, 1'b0);
    check("R6", int'(pwr_down), 0);

    // R10 bits change without strobe, reference edges without pending
    phase = "R10";
    pd_req = 1'b1; pd_mode = 1'b0; step(3);
    ref_tick(); ref_tick();
    check("R10", int'(pwr_down), 0);
    pd_req = 1'b0;

    // R3 deferred entry on second reference edge
    phase = "R3";
    strobe(1'b1, 1'b1);
    check("R3", int'(pending), 1);
    ref_tick();
    check("R3", int'(pwr_down), 0);
    refp = 1'b1; step(1);
    check("R3", int'(pwr_down), 1);
    refp = 1'b0; step(1);
    strobe(1'b0, 1'b0);

    // R3 reference edge coincident with the strobe edge is not counted
    pd_req = 1'b1; pd_mode = 1'b1; step(1);
    latch = 1'b1; refp = 1'b1; step(1);
    latch = 1'b0; refp = 1'b0; step(1);
    ref_tick();
    check("R3", int'(pwr_down), 0);
    ref_tick();
    check("R3", int'(pwr_down), 1);
    strobe(1'b0, 1'b0);

    // R7 restart of the count by a new deferred strobe
    phase = "R7";
    strobe(1'b1, 1'b1);
    ref_tick();
    strobe(1'b1, 1'b1);
    ref_tick();
    check("R7", int'(pwr_down), 0);
    ref_tick();
    check("R7", int'(pwr_down), 1);
    strobe(1'b0, 1'b0);

    // R6 cancel of a pending request
    phase = "R6";
    strobe(1'b1, 1'b1);
    ref_tick();
    strobe(1'b0, 1'b1);
    check("R6", int'(pending), 0);
    ref_tick(); ref_tick();
    check("R6", int'(pwr_down), 0);

    // R4 chip enable override, same cycle
    phase = "R4";
    chip_en = 1'b0; #1;
    check("R4", int'(pwr_down), 1);
    step(2);
    chip_en = 1'b1; step(2);
    check("R4", int'(pwr_down), 0);
    strobe(1'b1, 1'b0);
    chip_en = 1'b0; step(2);
    chip_en = 1'b1; step(1);
    check("R4", int'(pwr_down), 1);

    // R9 deferred request while already down
    phase = "R9";
    strobe(1'b1, 1'b1);
    check("R9", int'(pending), 0);
    check("R9", int'(pwr_down), 1);
    strobe(1'b0, 1'b0);

    // mixed pattern with chip enable low during pending count
    phase = "R4";
    strobe(1'b1, 1'b1);
    chip_en = 1'b0;
    ref_tick();
    chip_en = 1'b1;
    ref_tick();
    check("R3", int'(pwr_down), 1);
    step(4);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule